// File: doc/BRIEF.md
# Two-Bank SDRAM Command Timing Checker

This block watches the command strobes and address bus that a memory controller drives toward a two-bank SDRAM. On every rising clock edge it decodes the strobe pattern into a command. It keeps track of whether each bank holds an open row. It also checks three spacing rules, each against a programmable cycle count: activate to column access in the same bank, activate to activate in the same bank, and activate in one bank to activate in the other.

Every decoded command is judged once. A legal command produces a one-cycle acceptance pulse and updates the bank state. An illegal one produces a one-cycle error pulse that carries a cause code and the bank it targeted, and it leaves all bank state untouched.

The checker never drives the memory and has no effect on the command stream. It is meant for protocol monitoring and for guarding a controller during bring-up.

Top module: `sdram_cmd_checker`

## Requirements
- R1: Commands are decoded from the active-low strobes (cs_n, ras_n, cas_n, we_n) at the rising edge, as follows:
  - activate = 0,0,1,1
  - read = 0,1,0,1
  - write = 0,1,0,0
  - precharge = 0,0,1,0
  - NOP = 0,1,1,1
  - any pattern with cs_n high is a deselect.
- R2: After reset both banks are closed (bank_open = 2'b00) and cmd_ok and err_valid are low.
- R3: An activate to a closed bank that meets the timing rules is accepted and opens that bank. Address bit 11 selects the bank: 0 selects bank A (bank_open bit 0) and 1 selects bank B (bank_open bit 1).
- R4: A read or write to a closed bank is rejected with code 1.
- R5: A read or write issued fewer than cfg_trcd cycles after its bank's activate is rejected with code 2. An access exactly cfg_trcd cycles after the activate is accepted, and a setting of 0 or 1 allows an access on the very next cycle.
- R6: An activate to a bank that is already open is rejected with code 5.
- R7: An activate issued fewer than cfg_trc cycles after the previous accepted activate to the same bank is rejected with code 3.
- R8: An activate issued fewer than cfg_trrd cycles after an accepted activate to the other bank is rejected with code 4. When several rules fail at once, code 5 wins over code 3, and code 3 wins over code 4.
- R9: A precharge with address bit 10 high closes both banks. With bit 10 low it closes only the bank selected by bit 11. A precharge is always accepted.
- R10: An accepted write with address bit 10 high closes its bank, and that bank may be activated again once cfg_trc has elapsed.
- R11: A rejected command, a NOP and a deselect leave bank_open unchanged and raise neither pulse.
- R12: The verdict appears one cycle after the command edge and lasts one cycle:
  - cmd_ok high means the command was accepted;
  - err_valid high means it was rejected, with err_code holding the cause and err_bank holding the targeted bank;
  - err_code is 0 whenever err_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| addr | input | ADDR_W (12) | Address bus; bit 11 bank select, bit 10 auto/all-bank flag |
| cfg_trcd | input | CNT_W (4) | Activate-to-access spacing in cycles |
| cfg_trc | input | CNT_W (4) | Same-bank activate spacing in cycles |
| cfg_trrd | input | CNT_W (4) | Cross-bank activate spacing in cycles |
| cmd_ok | output | 1 | One-cycle pulse: command accepted |
| err_valid | output | 1 | One-cycle pulse: command rejected |
| err_code | output | 3 | Rejection cause: 1 idle, 2 tRCD, 3 tRC, 4 tRRD, 5 open bank |
| err_bank | output | 1 | Bank targeted by the rejected command |
| bank_open | output | 2 | Open flags, bit 0 bank A, bit 1 bank B |

## Verification
The bench first runs with the activate-to-access spacing at 3 cycles, the same-bank spacing at 6 and the cross-bank spacing at 2. These values are small enough that each rule can be hit one cycle early and exactly on its boundary within a few commands. They also make the same-bank and cross-bank limits expire at different times, so a single activate can break two rules at once and expose the priority between their codes. The bench then lowers the activate-to-access spacing to 1 to reach the case where a column access follows its activate on the very next cycle.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0,
        ERR_IDLE = 3'd1,
        ERR_RCD  = 3'd2,
        ERR_RC   = 3'd3,
        ERR_RRD  = 3'd4,
        ERR_OPEN = 3'd5
    } err_e;
endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
    import sdc_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NONE;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             close_i,
    input  logic [CNT_W-1:0] t_rcd,
    input  logic [CNT_W-1:0] t_rc,
    output logic             open_o,
    output logic             rcd_met_o,
    output logic             rc_met_o
);
    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] rcd;
        logic [CNT_W-1:0] rc;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] sat_dec(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.rcd  = sat_dec(st_q.rcd);
        st_d.rc   = sat_dec(st_q.rc);
        if (act_i) begin
            st_d.open = 1'b1;
            st_d.rcd  = sat_dec(t_rcd);
            st_d.rc   = sat_dec(t_rc);
        end else if (close_i) begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o    = st_q.open;
    assign rcd_met_o = (st_q.rcd == '0);
    assign rc_met_o  = (st_q.rc == '0);
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdc_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BANK_BIT = 11,
    parameter int AP_BIT   = 10,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cfg_trcd,
    input  logic [CNT_W-1:0]  cfg_trc,
    input  logic [CNT_W-1:0]  cfg_trrd,
    output logic              cmd_ok,
    output logic              err_valid,
    output logic [2:0]        err_code,
    output logic              err_bank,
    output logic [1:0]        bank_open
);
    localparam int NBANK = 2;

    typedef struct packed {
        logic             ok;
        logic             err;
        err_e             code;
        logic             ebank;
        logic [CNT_W-1:0] rrd;
        logic             last_bank;
    } top_st_t;

    top_st_t st_d, st_q;

    cmd_e             cmd;
    logic             sel;
    logic             ap;
    logic [NBANK-1:0] act_vec, close_vec;
    logic [NBANK-1:0] open_vec, rcd_met, rc_met;
    err_e             code;

    assign sel = addr[BANK_BIT];
    assign ap  = addr[AP_BIT];

    sdc_decode i_decode (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sdc_bank #(.CNT_W(CNT_W)) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (act_vec[b]),
            .close_i  (close_vec[b]),
            .t_rcd    (cfg_trcd),
            .t_rc     (cfg_trc),
            .open_o   (open_vec[b]),
            .rcd_met_o(rcd_met[b]),
            .rc_met_o (rc_met[b])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.rrd  = (st_q.rrd == '0) ? '0 : st_q.rrd - 1'b1;
        code      = ERR_NONE;
        act_vec   = '0;
        close_vec = '0;
        unique case (cmd)
            CMD_ACT: begin
                if (open_vec[sel])                              code = ERR_OPEN;
                else if (!rc_met[sel])                          code = ERR_RC;
                else if (sel != st_q.last_bank && st_q.rrd != '0) code = ERR_RRD;
                else begin
                    act_vec[sel]   = 1'b1;
                    st_d.rrd       = (cfg_trrd == '0) ? '0 : cfg_trrd - 1'b1;
                    st_d.last_bank = sel;
                end
            end
            CMD_READ, CMD_WRITE: begin
                if (!open_vec[sel])       code = ERR_IDLE;
                else if (!rcd_met[sel])   code = ERR_RCD;
                else if (cmd == CMD_WRITE && ap) close_vec[sel] = 1'b1;
            end
            CMD_PRE: begin
                if (ap) close_vec      = '1;
                else    close_vec[sel] = 1'b1;
            end
            default: ;
        endcase
        st_d.ok    = (cmd != CMD_NONE) && (code == ERR_NONE);
        st_d.err   = (code != ERR_NONE);
        st_d.code  = code;
        st_d.ebank = (code != ERR_NONE) ? sel : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_ok    = st_q.ok;
    assign err_valid = st_q.err;
    assign err_code  = st_q.code;
    assign err_bank  = st_q.ebank;
    assign bank_open = open_vec;
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
    parameter int ADDR_W   = 12,
    parameter int BANK_BIT = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              cmd_ok,
    input logic              err_valid,
    input logic [2:0]        err_code,
    input logic [1:0]        bank_open
);
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    logic is_access, is_act, tgt_open;
    assign is_access = !cs_n && ras_n && !cas_n;
    assign is_act    = !cs_n && !ras_n && cas_n && we_n;
    assign tgt_open  = bank_open[addr[BANK_BIT]];

    // R12
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ok && err_valid));

    // R12
    code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> err_code == 3'd0);

    // R11
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && cs_n |=> !cmd_ok && !err_valid && $stable(bank_open));

    // R4
    idle_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && is_access && !tgt_open |=> err_valid && err_code == 3'd1);

    // R6
    open_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && is_act && tgt_open |=> err_valid && err_code == 3'd5);

    // R11
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $stable(bank_open));
endmodule

bind sdram_cmd_checker sdc_checker #(
    .ADDR_W  (ADDR_W),
    .BANK_BIT(BANK_BIT)
) i_sdc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .addr     (addr),
    .cmd_ok   (cmd_ok),
    .err_valid(err_valid),
    .err_code (err_code),
    .bank_open(bank_open)
);

// File: tb/test_sdram_cmd_checker.sv
module test_sdram_cmd_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [3:0]  cfg_trcd = 4'd3, cfg_trc = 4'd6, cfg_trrd = 4'd2;
    logic        cmd_ok, err_valid, err_bank;
    logic [2:0]  err_code;
    logic [1:0]  bank_open;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       ok;
        logic [2:0] code;
        logic       bank;
        logic [1:0] open;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    sdram_cmd_checker i_sdram_cmd_checker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .cfg_trcd(cfg_trcd), .cfg_trc(cfg_trc),
        .cfg_trrd(cfg_trrd), .cmd_ok(cmd_ok), .err_valid(err_valid),
        .err_code(err_code), .err_bank(err_bank), .bank_open(bank_open)
    );

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // strobes s = {cs_n,ras_n,cas_n,we_n}
    task automatic step(input logic [3:0] s, input logic bk, input logic a10,
                        input logic eok, input logic [2:0] ecode,
                        input logic [1:0] eopen, input string req);
        exp_t e;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = s;
        addr = {bk, a10, 10'h15A};
        e.ok = eok; e.code = ecode; e.bank = bk; e.open = eopen; e.req = req;
        sb.push_back(e);
    endtask

    localparam logic [3:0] ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                           PRE = 4'b0010, NOP = 4'b0111, DSL_ACT = 4'b1011;

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(cmd_ok == e.ok, e.req, "cmd_ok", cmd_ok, e.ok);
                check(err_valid == (e.code != 0), e.req, "err_valid", err_valid, e.code != 0);
                check(err_code == e.code, e.req, "err_code", err_code, e.code);
                if (e.code != 0)
                    check(err_bank == e.bank, e.req, "err_bank", err_bank, e.bank);
                check(bank_open == e.open, e.req, "bank_open", bank_open, e.open);
            end
        end
    end

    // watchdog
    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bank_open == 2'b00, "R2", "bank_open", bank_open, 0);
        check(!cmd_ok && !err_valid, "R2", "pulses", cmd_ok | err_valid, 0);
        rst_n = 1'b1;
        step(ACT, 0, 0, 1, 0, 2'b01, "R3 R1 act A");
        step(RD,  0, 0, 0, 2, 2'b01, "R5 early read");
        step(ACT, 1, 0, 1, 0, 2'b11, "R8 rrd boundary");
        step(WR,  0, 0, 1, 0, 2'b11, "R5 trcd boundary");
        step(ACT, 0, 0, 0, 5, 2'b11, "R6 open act");
        step(RD,  1, 0, 1, 0, 2'b11, "R1 read B");
        step(PRE, 0, 0, 1, 0, 2'b10, "R9 pre A");
        step(ACT, 0, 0, 1, 0, 2'b11, "R3 reopen A");
        step(PRE, 0, 1, 1, 0, 2'b00, "R9 pre all");
        step(RD,  1, 0, 0, 1, 2'b00, "R4 idle read");
        step(ACT, 1, 0, 1, 0, 2'b10, "R3 act B");
        step(ACT, 0, 0, 0, 3, 2'b10, "R7 R8 rc before rrd");
        step(DSL_ACT, 0, 0, 0, 0, 2'b10, "R11 deselect");
        step(ACT, 0, 0, 1, 0, 2'b11, "R7 trc boundary");
        step(WR,  0, 1, 0, 2, 2'b11, "R11 rejected write keeps bank");
        step(NOP, 0, 0, 0, 0, 2'b11, "R11 nop");
        step(WR,  0, 1, 1, 0, 2'b10, "R10 write autoclose");
        step(PRE, 1, 0, 1, 0, 2'b00, "R9 pre B");
        step(ACT, 1, 0, 1, 0, 2'b10, "R3 act B again");
        step(ACT, 0, 0, 0, 4, 2'b10, "R8 rrd early");
        step(ACT, 0, 0, 1, 0, 2'b11, "R10 reopen after autoclose");
        step(PRE, 0, 1, 1, 0, 2'b00, "R9 pre all 2");
        @(negedge clk); cfg_trcd = 4'd1;
        {cs_n, ras_n, cas_n, we_n} = NOP;
        begin exp_t e; e.ok = 0; e.code = 0; e.bank = 0; e.open = 2'b00; e.req = "R11 nop2"; sb.push_back(e); end
        step(NOP, 0, 0, 0, 0, 2'b00, "R11 nop3");
        step(NOP, 0, 0, 0, 0, 2'b00, "R11 nop4");
        step(ACT, 1, 0, 1, 0, 2'b10, "R3 act B trcd1");
        step(RD,  1, 0, 1, 0, 2'b10, "R5 trcd one next cycle");
        step(NOP, 0, 0, 0, 0, 2'b10, "R12 pulse one cycle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule